// File: doc/BRIEF.md
# I2C Bus Unhang Engine

This block frees a two-wire bus that a target device has left stuck, typically because the system was reset partway through a byte and the target still holds the data line low, or holds the clock low while stretching. After a single start request the engine lets both lines float high. It then waits, with a bounded timeout, until the clock line reads high. Next it clocks the bus by hand until the target lets go of the data line, and it closes with a START and a STOP so that every target returns to its idle state. The engine reports completion together with a pass or bus-error result.

The engine only pulls lines low or releases them, so it suits open-drain pads with external pull-ups. Both line inputs pass through a two-stage synchronizer before any decision is based on them. All delays are whole microseconds, counted by a prescaler whose divide ratio is derived from the clock-frequency parameter. The owning controller starts the engine after a failed transfer or after its own reset and waits for `done_o`. A healthy bus is not left alone: it still gets the closing START/STOP pair, which takes only about ten microseconds.

Top module: `i2c_bus_unhang`

## Requirements
- R1: A start request that is sampled while idle is accepted. From the next cycle `busy_o` is high and both line enables are deasserted, so both lines float.
- R2: The synchronized clock line is polled once on acceptance and then once every POLL_US microseconds, with the poll cycle itself added to each interval. If the 80th poll (LIMIT_US/POLL_US) still reads low, the run ends with `error_o` high and no clock pulse or START is sent.
- R3: Once the clock line reads high, the synchronized data line is sampled before each clock pulse. A high reading ends the pulse phase at once. A bus whose data line is already free gets no pulses.
- R4: Each recovery pulse asserts `scl_oe_o` for exactly HALF_US microseconds and then releases it for HALF_US microseconds before the data line is sampled again.
- R5: No more than MAX_PULSES (9) pulses are sent. If the data line still reads low at the sample taken after the ninth pulse, the run ends with `error_o` high and no START is sent. A data line that frees during the ninth pulse still passes.
- R6: After the data line is seen free, `sda_oe_o` is asserted for HALF_US microseconds while the clock line stays released (START). It is then released for HALF_US microseconds (STOP), and the run ends with `error_o` low. The two enables are never asserted together.
- R7: On a healthy bus, `done_o` is high in the cycle that comes 2*HALF_US*(CLK_HZ/1e6)+3 clock cycles after the cycle in which the start request is first sampled.
- R8: `busy_o` stays high from acceptance through the `done_o` cycle and is low in the following cycle. A start request made while busy has no effect.
- R9: `done_o` is high for exactly one cycle per accepted request. `error_o` is high only in that cycle, and only for a failed run.
- R10: During reset, after reset, and after every completion, `busy_o`, `scl_oe_o` and `sda_oe_o` are all low, which leaves the bus idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to run the recovery sequence |
| scl_i | input | 1 | Raw clock-line level read back from the pad |
| sda_i | input | 1 | Raw data-line level read back from the pad |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Bus-error result, valid with done_o |
| scl_oe_o | output | 1 | Pull the clock line low when high |
| sda_oe_o | output | 1 | Pull the data line low when high |

## Verification
All outputs decode the registered state. Each result therefore shows up in the cycle that follows the edge that decided it, and line levels reach that decision two edges after they appear on the pad. The bench model counts out the same edges: a healthy bus finishes 2*HALF+3 cycles after the start is sampled, each pulse adds 2*HALF+1 cycles, and each failed clock poll adds POLL+1 cycles. The bench samples every output at the falling edge, half a cycle away from the edge that changes it. Per-run checks compare the measured completion cycle against those sums, including the worst case of 80 failed polls.

// File: rtl/rb_unhang_pkg.sv
`timescale 1ns/1ps
package rb_unhang_pkg;

    // Sequencer phases; the line enables are decoded directly from these.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL,    // one-cycle look at the synchronized clock line
        ST_PWAIT,   // gap between clock-line polls
        ST_CHECK,   // one-cycle look at the synchronized data line
        ST_CLO,     // recovery pulse, clock pulled low
        ST_CHI,     // recovery pulse, clock released
        ST_SSTART,  // data pulled low with clock high
        ST_SSTOP,   // data released with clock high
        ST_FIN      // completion cycle
    } rb_state_e;

endpackage

// File: rtl/rb_sync2.sv
`timescale 1ns/1ps
module rb_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // Two flops per bit; reset to the released (high) level of a pulled-up line.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, stable_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                meta_q   <= 1'b1;
                stable_q <= 1'b1;
            end else begin
                meta_q   <= d_i[b];
                stable_q <= meta_q;
            end
        end
        assign q_o[b] = stable_q;
    end

endmodule

// File: rtl/rb_us_tick.sv
`timescale 1ns/1ps
module rb_us_tick #(
    parameter int CYC_PER_US = 50
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);

    if (CYC_PER_US <= 1) begin : g_direct
        // Every cycle is a microsecond.
        assign tick_o = 1'b1;
    end else begin : g_div
        localparam int CW = $clog2(CYC_PER_US);
        localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            if (clr_i || cnt_q == LAST) cnt_d = '0;
            else                        cnt_d = cnt_q + CW'(1);
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) cnt_q <= '0;
            else         cnt_q <= cnt_d;
        end

        assign tick_o = (cnt_q == LAST);
    end

endmodule

// File: rtl/i2c_bus_unhang.sv
`timescale 1ns/1ps
module i2c_bus_unhang
    import rb_unhang_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int HALF_US    = 5,
    parameter int POLL_US    = 500,
    parameter int LIMIT_US   = 40_000,
    parameter int MAX_PULSES = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy_o,
    output logic done_o,
    output logic error_o,
    output logic scl_oe_o,
    output logic sda_oe_o
);

    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int POLLS      = LIMIT_US / POLL_US;
    localparam int TMR_MAX    = (POLL_US > HALF_US) ? POLL_US : HALF_US;
    localparam int CNT_MAX    = (POLLS > MAX_PULSES) ? POLLS : MAX_PULSES;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    localparam logic [TMR_W-1:0] POLL_LAST = TMR_W'(POLL_US - 1);
    localparam logic [TMR_W-1:0] HALF_LAST = TMR_W'(HALF_US - 1);
    localparam logic [CNT_W-1:0] POLL_CAP  = CNT_W'(POLLS - 1);
    localparam logic [CNT_W-1:0] PULSE_CAP = CNT_W'(MAX_PULSES);

    typedef struct packed {
        rb_state_e        state;
        logic [TMR_W-1:0] tmr;   // microseconds spent in a timed phase
        logic [CNT_W-1:0] cnt;   // failed polls, then pulses sent
        logic             err;
    } rb_regs_t;

    rb_regs_t cur_q, nxt_d;
    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       us_tick;
    logic       phase_change;

    rb_sync2 #(.WIDTH(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({scl_i, sda_i}),
        .q_o    (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    rb_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (phase_change),
        .tick_o (us_tick)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE: begin
                nxt_d.err = 1'b0;
                if (start_i) begin
                    nxt_d.state = ST_POLL;
                    nxt_d.cnt   = '0;
                end
            end
            ST_POLL: begin
                if (scl_s) begin
                    nxt_d.state = ST_CHECK;
                    nxt_d.cnt   = '0;
                end else if (cur_q.cnt == POLL_CAP) begin
                    nxt_d.state = ST_FIN;
                    nxt_d.err   = 1'b1;
                end else begin
                    nxt_d.state = ST_PWAIT;
                    nxt_d.cnt   = cur_q.cnt + CNT_W'(1);
                end
            end
            ST_PWAIT: begin
                if (us_tick) begin
                    if (cur_q.tmr == POLL_LAST) nxt_d.state = ST_POLL;
                    else                        nxt_d.tmr   = cur_q.tmr + TMR_W'(1);
                end
            end
            ST_CHECK: begin
                if (sda_s) begin
                    nxt_d.state = ST_SSTART;
                end else if (cur_q.cnt == PULSE_CAP) begin
                    nxt_d.state = ST_FIN;
                    nxt_d.err   = 1'b1;
                end else begin
                    nxt_d.state = ST_CLO;
                end
            end
            ST_CLO: begin
                if (us_tick) begin
                    if (cur_q.tmr == HALF_LAST) nxt_d.state = ST_CHI;
                    else                        nxt_d.tmr   = cur_q.tmr + TMR_W'(1);
                end
            end
            ST_CHI: begin
                if (us_tick) begin
                    if (cur_q.tmr == HALF_LAST) begin
                        nxt_d.state = ST_CHECK;
                        nxt_d.cnt   = cur_q.cnt + CNT_W'(1);
                    end else begin
                        nxt_d.tmr = cur_q.tmr + TMR_W'(1);
                    end
                end
            end
            ST_SSTART: begin
                if (us_tick) begin
                    if (cur_q.tmr == HALF_LAST) nxt_d.state = ST_SSTOP;
                    else                        nxt_d.tmr   = cur_q.tmr + TMR_W'(1);
                end
            end
            ST_SSTOP: begin
                if (us_tick) begin
                    if (cur_q.tmr == HALF_LAST) nxt_d.state = ST_FIN;
                    else                        nxt_d.tmr   = cur_q.tmr + TMR_W'(1);
                end
            end
            ST_FIN:  nxt_d.state = ST_IDLE;
            default: nxt_d.state = ST_IDLE;
        endcase
        // Each phase starts its microsecond count from zero.
        if (nxt_d.state != cur_q.state) nxt_d.tmr = '0;
    end

    assign phase_change = (nxt_d.state != cur_q.state);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.state <= ST_IDLE;
            cur_q.tmr   <= '0;
            cur_q.cnt   <= '0;
            cur_q.err   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o   = (cur_q.state != ST_IDLE);
    assign done_o   = (cur_q.state == ST_FIN);
    assign error_o  = (cur_q.state == ST_FIN) && cur_q.err;
    assign scl_oe_o = (cur_q.state == ST_CLO);
    assign sda_oe_o = (cur_q.state == ST_SSTART);

endmodule

// File: rtl/rb_unhang_checker.sv
`timescale 1ns/1ps
module rb_unhang_checker #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int HALF_US    = 5,
    parameter int MAX_PULSES = 9
) (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic scl_oe_o,
    input logic sda_oe_o
);

    localparam int HALF_CYC = HALF_US * (CLK_HZ / 1_000_000);

    int   scl_run, sda_run, pulses;
    logic scl_prev;

    // Lengths of the current low drives and pulses since the last acceptance.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_run  <= 0;
            sda_run  <= 0;
            pulses   <= 0;
            scl_prev <= 1'b0;
        end else begin
            scl_run  <= scl_oe_o ? scl_run + 1 : 0;
            sda_run  <= sda_oe_o ? sda_run + 1 : 0;
            scl_prev <= scl_oe_o;
            if (start_i && !busy_o)       pulses <= 0;
            else if (scl_oe_o && !scl_prev) pulses <= pulses + 1;
        end
    end

    p_release_on_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o && !scl_oe_o && !sda_oe_o));

    p_low_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_oe_o) |-> (scl_run == HALF_CYC));

    p_pulse_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulses <= MAX_PULSES);

    p_start_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sda_oe_o) |-> (sda_run == HALF_CYC));

    p_oe_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(scl_oe_o && sda_oe_o));

    p_busy_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy_o);

    p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_idle_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!scl_oe_o && !sda_oe_o));

endmodule

bind i2c_bus_unhang rb_unhang_checker #(
    .CLK_HZ     (CLK_HZ),
    .HALF_US    (HALF_US),
    .MAX_PULSES (MAX_PULSES)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
);

// File: tb/i2c_bus_unhang_test.sv
`timescale 1ns/1ps
module i2c_bus_unhang_test;

    localparam int CLK_HZ = 2_000_000;
    localparam int CPU    = CLK_HZ / 1_000_000;
    localparam int HUS    = 5;
    localparam int PUS    = 500;
    localparam int LUS    = 40_000;
    localparam int MAXP   = 9;
    localparam int H      = HUS * CPU;
    localparam int P      = PUS * CPU;
    localparam int POLLS  = LUS / PUS;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, error, scl_oe, sda_oe;
    logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
    logic scl_line, sda_line;

    assign scl_line = ~scl_oe & ~tgt_scl_low;
    assign sda_line = ~sda_oe & ~tgt_sda_low;

    always #10 clk = ~clk;

    i2c_bus_unhang #(
        .CLK_HZ(CLK_HZ), .HALF_US(HUS), .POLL_US(PUS), .LIMIT_US(LUS), .MAX_PULSES(MAXP)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
        .busy_o(busy), .done_o(done), .error_o(error), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- target device model ----------------
    int req_scl = 0, req_sda = 0, req_seq = 0, ld_seq = 0;
    int scl_left = 0, sda_left = 0;
    logic prev_line = 1'b1;
    always @(negedge clk) begin
        if (req_seq != ld_seq) begin
            ld_seq   = req_seq;
            scl_left = req_scl;
            sda_left = req_sda;
        end else begin
            if (scl_left > 0) scl_left--;
            if (prev_line && !scl_line && sda_left > 0) sda_left--;
        end
        tgt_scl_low = (scl_left > 0);
        tgt_sda_low = (sda_left > 0);
        prev_line   = ~scl_oe & ~tgt_scl_low;
    end

    // ---------------- behavioural reference ----------------
    logic exp_busy = 0, exp_done = 0, exp_err = 0, exp_scl_oe = 0, exp_sda_oe = 0;
    logic m_scl1 = 1, m_scl2 = 1, m_sda1 = 1, m_sda2 = 1, seen_scl = 1, seen_sda = 1;

    task mstep();
        @(posedge clk);
        seen_scl = m_scl2;
        seen_sda = m_sda2;
        m_scl2   = m_scl1;
        m_sda2   = m_sda1;
        m_scl1   = ~exp_scl_oe & ~tgt_scl_low;
        m_sda1   = ~exp_sda_oe & ~tgt_sda_low;
        if (!rst_n) begin
            m_scl1 = 1; m_scl2 = 1; m_sda1 = 1; m_sda2 = 1;
        end
    endtask

    task model_run();
        bit failed, ended;
        failed = 0; ended = 0;
        exp_busy = 1;
        for (int p = 0; ; p++) begin
            mstep();
            if (seen_scl) break;
            if (p == POLLS - 1) begin failed = 1; ended = 1; break; end
            repeat (P) mstep();
        end
        if (!ended) begin
            for (int n = 0; ; n++) begin
                mstep();
                if (seen_sda) break;
                if (n == MAXP) begin failed = 1; ended = 1; break; end
                exp_scl_oe = 1;
                repeat (H) mstep();
                exp_scl_oe = 0;
                repeat (H) mstep();
            end
        end
        if (!ended) begin
            exp_sda_oe = 1;
            repeat (H) mstep();
            exp_sda_oe = 0;
            repeat (H) mstep();
        end
        exp_done = 1;
        exp_err  = failed;
        mstep();
        exp_done = 0;
        exp_err  = 0;
        exp_busy = 0;
    endtask

    initial begin : ref_model
        forever begin
            mstep();
            if (!rst_n) begin
                exp_busy = 0; exp_done = 0; exp_err = 0; exp_scl_oe = 0; exp_sda_oe = 0;
            end else if (start && !exp_busy) begin
                model_run();
            end
        end
    end

    // ---------------- per-clock comparison and edge counting ----------------
    int scl_rises = 0, sda_rises = 0;
    logic prev_scl_oe = 0, prev_sda_oe = 0;
    always @(negedge clk) begin
        if (!finished) begin
            total++;
            if (busy !== exp_busy || done !== exp_done || error !== exp_err ||
                scl_oe !== exp_scl_oe || sda_oe !== exp_sda_oe) begin
                bad++;
                if (busy !== exp_busy)     $display("FAIL R8 busy actual=%0d expected=%0d", busy, exp_busy);
                if (done !== exp_done)     $display("FAIL R9 done actual=%0d expected=%0d", done, exp_done);
                if (error !== exp_err)     $display("FAIL R9 error actual=%0d expected=%0d", error, exp_err);
                if (scl_oe !== exp_scl_oe) $display("FAIL R4 scl_oe actual=%0d expected=%0d", scl_oe, exp_scl_oe);
                if (sda_oe !== exp_sda_oe) $display("FAIL R6 sda_oe actual=%0d expected=%0d", sda_oe, exp_sda_oe);
            end
        end
        if (scl_oe === 1'b1 && !prev_scl_oe) scl_rises++;
        if (sda_oe === 1'b1 && !prev_sda_oe) sda_rises++;
        prev_scl_oe = (scl_oe === 1'b1);
        prev_sda_oe = (sda_oe === 1'b1);
    end

    // ---------------- one recovery run ----------------
    task automatic run_case(input string tag, input int scl_hold, input int sda_hold,
                            input bit exp_e, input int exp_pulses, input int exp_starts,
                            input int exp_lat, input bit rebump);
        int n, p0, s0;
        bit got;
        @(posedge clk); #3;
        req_scl = scl_hold; req_sda = sda_hold; req_seq++;
        @(posedge clk); #3;
        p0 = scl_rises; s0 = sda_rises;
        start = 1; n = 0; got = 0;
        while (!got && n < 150000) begin
            @(negedge clk);
            n++;
            if (n == 2) begin
                start = 0;
                chk(busy === 1'b1 && scl_oe === 1'b0 && sda_oe === 1'b0,
                    {"R1 accept ", tag}, busy, 1);
            end
            if (rebump && n == 4) start = 1;
            if (rebump && n == 6) start = 0;
            if (done === 1'b1) got = 1;
        end
        chk(got, {"R9 done seen ", tag}, got, 1);
        chk(error === exp_e, {"R9 result ", tag}, error, exp_e);
        chk(scl_rises - p0 == exp_pulses, {"R3/R5 pulses ", tag}, scl_rises - p0, exp_pulses);
        chk(sda_rises - s0 == exp_starts, {"R6 start sent ", tag}, sda_rises - s0, exp_starts);
        chk(n == exp_lat, {"latency ", tag}, n, exp_lat);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(busy === 1'b0 && done === 1'b0 && scl_oe === 1'b0 && sda_oe === 1'b0,
                {"R8 R10 idle after done ", tag}, busy, 0);
        end
    endtask

    initial begin : stim
        repeat (3) @(posedge clk);
        #3 rst_n = 1;
        @(negedge clk);
        chk(busy === 0 && done === 0 && error === 0 && scl_oe === 0 && sda_oe === 0,
            "R10 reset state", busy, 0);
        // R7 R8: healthy bus, extra start while busy ignored
        run_case("R7 healthy", 0, 0, 0, 0, 1, 2*H + 4, 1);
        // R3 R4: data freed after three pulses
        run_case("R4 three pulses", 0, 3, 0, 3, 1, 4 + 3*(2*H + 1) + 2*H, 0);
        // R5: data freed during the ninth pulse
        run_case("R5 nine pulses", 0, 9, 0, 9, 1, 4 + 9*(2*H + 1) + 2*H, 0);
        // R5: data stuck forever
        run_case("R5 stuck data", 0, 1000, 1, 9, 0, 4 + 9*(2*H + 1), 0);
        // R2: clock stretched for a while
        run_case("R2 stretch", 1500, 0, 0, 0, 1, 4 + 2*(P + 1) + 2*H, 0);
        // R2: clock stuck low, timeout
        run_case("R2 timeout", 1_000_000, 0, 1, 0, 0, 3 + (POLLS - 1)*(P + 1), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        #(64'd3_900_000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule